// File: doc/BRIEF.md
# Two-Wire Controller Control and Status Registers

This block is the register set that software uses to steer a two-wire serial bus controller. It holds an 8-bit control word. Software changes that word through two write addresses. One address sets every bit written as 1. The other address clears every bit written as 1. Software reads the control word back through the set address. The control word drives the controller's control outputs, and one of its bits is the serial interrupt flag.

The bus engine raises that flag with a one-cycle strobe and supplies a 5-bit state code at the same time. The block latches the code and shifts it up by three bit positions. Each code value therefore reads as a multiple of 8, so software can add it directly to a table base as the offset of a handler slot. The code stays frozen for as long as the flag is pending. When no interrupt is pending, the status register reads an idle value.

The register bus is a plain synchronous interface. Writes complete in the cycle that `bus_we` is high, so there is no back-pressure. Read data is combinational from `bus_addr`. The strobe and the code are plain pins with no handshake.

Top module: `twi_ctl_regs`

## Requirements
- R1: After reset, the control word is 0x00, `irq` is 0, and the status address (offset 1) reads 0xF8.
- R2: A write to offset 0 sets every control bit where `bus_wdata` is 1 and leaves the other bits as they were. The change is visible from the next cycle.
- R3: A write to offset 2 clears every control bit where `bus_wdata` is 1 and leaves the other bits as they were.
- R4: A read of offset 0 returns the control word. Reads of offset 2 and offset 3 return 0x00.
- R5: A pulse on `hw_flag_set` while the flag (control bit 3) is clear does two things: the flag is 1 from the next cycle, and offset 1 then reads `{hw_code, 3'b000}`. This holds for codes 0x00 through 0x1F.
- R6: While the flag is pending, further pulses on `hw_flag_set` leave the status reading unchanged, even when they carry a different code.
- R7: When `hw_flag_set` and a write to offset 2 with bit 3 set occur in the same cycle, the flag ends up set. The other bits of that clear write still take effect. The status code follows R5 and R6.
- R8: While the flag is clear, offset 1 reads 0xF8. This includes the time after software has cleared a pending flag.
- R9: `irq` and `ctl_out` bit 3 always equal the flag. This is true whether hardware raised the flag or software set it through offset 0.
- R10: Writes to offset 1 (status) have no effect on the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset: 0 set/read control, 1 status, 2 clear |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 8 | Write data (bit mask for set/clear) |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| hw_flag_set | input | 1 | Strobe from the bus engine that raises the interrupt flag |
| hw_code | input | 5 | State code that accompanies `hw_flag_set` |
| ctl_out | output | 8 | Current control word |
| irq | output | 1 | Serial interrupt flag |

## Verification
The hardest situation to reach is a cycle in which the hardware strobe and a software clear of the flag collide. The test must cover this collision twice: once with the flag already pending and once with it idle, because the status code is expected to behave differently in each case. The stimulus builds each collision on purpose. A single driver step raises `hw_flag_set` and, in the same cycle, writes a clear mask to offset 2. That mask also hits another control bit, so the test can see that the rest of the clear still takes effect. The test then reads back both the control word and the status to check the result.

// File: rtl/twi_regs_pkg.sv
package twi_regs_pkg;
  // register offsets on the local bus
  localparam int unsigned OFS_SET  = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_CLR  = 2;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ZERO = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/twi_regs_decode.sv
module twi_regs_decode
  import twi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              set_wr,
  output logic              clr_wr,
  output rd_sel_e           sel
);
  logic hit_set, hit_clr, hit_stat;

  assign hit_set  = (addr == ADDR_W'(OFS_SET));
  assign hit_clr  = (addr == ADDR_W'(OFS_CLR));
  assign hit_stat = (addr == ADDR_W'(OFS_STAT));

  assign set_wr = we & hit_set;
  assign clr_wr = we & hit_clr;

  always_comb begin
    if (hit_set)       sel = SEL_CTL;
    else if (hit_stat) sel = SEL_STAT;
    else               sel = SEL_ZERO;
  end
endmodule

// File: rtl/twi_regs_ctl_bank.sv
module twi_regs_ctl_bank #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FLAG_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hw_set,
  output logic [DATA_W-1:0] ctl_q
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic bit_q;
    if (i == FLAG_BIT) begin : g_flag
      // hardware raise has priority over a software clear
      always_ff @(posedge clk) begin
        if (!rst_n)                 bit_q <= 1'b0;
        else if (hw_set)            bit_q <= 1'b1;
        else if (clr_wr && wdata[i]) bit_q <= 1'b0;
        else if (set_wr && wdata[i]) bit_q <= 1'b1;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)                 bit_q <= 1'b0;
        else if (clr_wr && wdata[i]) bit_q <= 1'b0;
        else if (set_wr && wdata[i]) bit_q <= 1'b1;
      end
    end
    assign ctl_q[i] = bit_q;
  end
endmodule

// File: rtl/twi_regs_stat_latch.sv
module twi_regs_stat_latch #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_set,
  input  logic              pending,
  input  logic [CODE_W-1:0] hw_code,
  output logic [CODE_W-1:0] code_q,
  output logic [DATA_W-1:0] stat_view
);
  localparam int unsigned PAD_W = DATA_W - CODE_W;
  localparam logic [DATA_W-1:0] IDLE_VAL = {{CODE_W{1'b1}}, {PAD_W{1'b0}}};

  // capture only on the edge that makes the flag pending
  always_ff @(posedge clk) begin
    if (!rst_n)                  code_q <= '1;
    else if (hw_set && !pending) code_q <= hw_code;
  end

  assign stat_view = pending ? {code_q, {PAD_W{1'b0}}} : IDLE_VAL;
endmodule

// File: rtl/twi_ctl_regs.sv
module twi_ctl_regs
  import twi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned FLAG_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hw_flag_set,
  input  logic [CODE_W-1:0] hw_code,
  output logic [DATA_W-1:0] ctl_out,
  output logic              irq
);
  logic              set_wr, clr_wr;
  rd_sel_e           sel;
  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] stat_view;
  logic [CODE_W-1:0] cap_code;

  twi_regs_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .we(bus_we), .set_wr(set_wr), .clr_wr(clr_wr), .sel(sel)
  );

  twi_regs_ctl_bank #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .set_wr(set_wr), .clr_wr(clr_wr),
    .wdata(bus_wdata), .hw_set(hw_flag_set), .ctl_q(ctl_q)
  );

  twi_regs_stat_latch #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_flag_set), .pending(ctl_q[FLAG_BIT]),
    .hw_code(hw_code), .code_q(cap_code), .stat_view(stat_view)
  );

  always_comb begin
    unique case (sel)
      SEL_CTL:  bus_rdata = ctl_q;
      SEL_STAT: bus_rdata = stat_view;
      default:  bus_rdata = '0;
    endcase
  end

  assign ctl_out = ctl_q;
  assign irq     = ctl_q[FLAG_BIT];
endmodule

// File: rtl/twi_ctl_regs_chk.sv
module twi_ctl_regs_chk #(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned FLAG_BIT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              hw_flag_set,
  input logic [DATA_W-1:0] ctl_out,
  input logic              irq,
  input logic [CODE_W-1:0] cap_code
);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2);
  localparam logic [DATA_W-1:0] IDLE   = {{CODE_W{1'b1}}, {(DATA_W-CODE_W){1'b0}}};

  a_r2_set_or: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET && !hw_flag_set) |=>
      ctl_out == ($past(ctl_out) | $past(bus_wdata)));

  a_r3_clr_andn: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR && !hw_flag_set) |=>
      ctl_out == ($past(ctl_out) & ~$past(bus_wdata)));

  a_r5_raise: assert property (@(posedge clk) disable iff (!rst_n)
    hw_flag_set |=> irq);

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (!irq || cap_code == $past(cap_code)));

  a_r7_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_flag_set && bus_we && bus_addr == A_CLR && bus_wdata[FLAG_BIT]) |=> irq);

  a_r8_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && bus_addr == A_STAT) |-> bus_rdata == IDLE);

  a_r10_stat_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_STAT && !hw_flag_set) |=> $stable(ctl_out));
endmodule

bind twi_ctl_regs twi_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .FLAG_BIT(FLAG_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_flag_set(hw_flag_set),
  .ctl_out(ctl_out), .irq(irq), .cap_code(cap_code)
);

// File: tb/twi_ctl_regs_test.sv
`timescale 1ns/1ps
module twi_ctl_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       hw_flag_set = 1'b0;
  logic [4:0] hw_code = '0;
  logic [7:0] ctl_out;
  logic       irq;

  always #2.5 clk = ~clk;

  twi_ctl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_flag_set(hw_flag_set),
    .hw_code(hw_code), .ctl_out(ctl_out), .irq(irq)
  );

  typedef struct {
    logic [7:0] rd;
    logic       irq;
    string      req;
  } exp_t;

  exp_t q[$];
  logic probe = 1'b0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  // monitor: compare at the falling edge while a probe is open
  always @(negedge clk) begin
    if (probe && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (bus_rdata !== e.rd || irq !== e.irq || ctl_out[3] !== irq) begin
        n_err++;
        $display("FAIL %s: rdata=%h irq=%b ctl3=%b expected rdata=%h irq=%b",
                 e.req, bus_rdata, irq, ctl_out[3], e.rd, e.irq);
      end
    end
  end

  // one bus/strobe cycle; called at posedge+1
  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                      input logic hs, input logic [4:0] c);
    bus_we = we; bus_addr = a; bus_wdata = d; hw_flag_set = hs; hw_code = c;
    @(posedge clk); #1;
    bus_we = 1'b0; hw_flag_set = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 5'd0);
  endtask

  task automatic hw(input logic [4:0] c);
    step(1'b0, 2'd0, 8'h00, 1'b1, c);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input logic ei,
                    input string req);
    exp_t x;
    x.rd = e; x.irq = ei; x.req = req;
    bus_addr = a;
    q.push_back(x);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(2'd1, 8'hF8, 1'b0, "R1 status after reset");
    rd(2'd0, 8'h00, 1'b0, "R1 control after reset");
    wr(2'd0, 8'h41); rd(2'd0, 8'h41, 1'b0, "R2 set");
    wr(2'd0, 8'h24); rd(2'd0, 8'h65, 1'b0, "R2 set keeps others");
    wr(2'd2, 8'h44); rd(2'd0, 8'h21, 1'b0, "R3 clear");
    rd(2'd2, 8'h00, 1'b0, "R4 clear offset reads zero");
    rd(2'd3, 8'h00, 1'b0, "R4 unused offset reads zero");
    wr(2'd1, 8'hFF); rd(2'd0, 8'h21, 1'b0, "R10 status write ignored");
    hw(5'h05);
    rd(2'd0, 8'h29, 1'b1, "R9 flag bit follows raise");
    rd(2'd1, 8'h28, 1'b1, "R5 code aligned");
    hw(5'h1A); rd(2'd1, 8'h28, 1'b1, "R6 code frozen");
    step(1'b1, 2'd2, 8'h08, 1'b1, 5'h11);
    rd(2'd0, 8'h29, 1'b1, "R7 hw wins while pending");
    rd(2'd1, 8'h28, 1'b1, "R7 code kept while pending");
    wr(2'd2, 8'h08);
    rd(2'd1, 8'hF8, 1'b0, "R8 idle after clear");
    rd(2'd0, 8'h21, 1'b0, "R8 control after clear");
    step(1'b1, 2'd2, 8'h09, 1'b1, 5'h13);
    rd(2'd0, 8'h28, 1'b1, "R7 hw wins from idle, other clear applied");
    rd(2'd1, 8'h98, 1'b1, "R7 new code captured");
    wr(2'd2, 8'h08); rd(2'd1, 8'hF8, 1'b0, "R8 idle again");
    hw(5'h00); rd(2'd1, 8'h00, 1'b1, "R5 lowest code");
    wr(2'd2, 8'h08);
    hw(5'h1F); rd(2'd1, 8'hF8, 1'b1, "R5 highest code");
    wr(2'd2, 8'h08);
    wr(2'd0, 8'h08); rd(2'd0, 8'h28, 1'b1, "R9 software-set flag drives irq");
    wr(2'd2, 8'h28); rd(2'd0, 8'h00, 1'b0, "R9 irq drops with flag");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule